// File: doc/BRIEF.md
# Subband Transpose Buffer

This block sits between the row pass and the two column passes of a separable two-dimensional wavelet transform. The row stage delivers one low-pass and one high-pass coefficient on each accepted beat, in raster order. The buffer stores a complete first-pass frame. It keeps the low-pass half and the high-pass half in two separate memory banks, each `FRAME_H` rows by `FRAME_W/2` columns.

When the frame is complete, the buffer raises `frame_full` and stops accepting input. It then plays the frame back column by column, so that each column processor sees a column as one contiguous line. The low-pass bank and the high-pass bank are read in lockstep and leave as two parallel streams. A line-start flag marks the top of every column, and a done flag marks the final beat, after which the next frame may be written.

Top module: `subband_transpose`

## Requirements
- R1: While reset is applied, and until the internal reset release completes, `in_ready`, `frame_full`, `out_valid`, `out_line_start` and `out_frame_done` are all 0. After the release, `in_ready` is 1.
- R2: A beat is accepted when `in_valid` and `in_ready` are both 1. An accepted beat stores `in_l` and `in_h` at row `r`, column `c`, with address `r*(FRAME_W/2)+c`. The column advances first and the row advances at the end of each row.
- R3: `frame_full` rises in the cycle after the last beat of a frame (row `FRAME_H-1`, column `FRAME_W/2-1`) is accepted. `in_ready` is its inverse.
- R4: While `frame_full` is 1, `in_valid` and the input data are ignored. No stored value changes and the write position does not advance.
- R5: The first output beat appears one cycle after `frame_full` rises. One beat follows per cycle without gaps, in column order: column 0 rows 0 to `FRAME_H-1`, then column 1, and so on.
- R6: On each output beat, `out_l` and `out_h` carry the low-pass and high-pass values stored at the same row and column.
- R7: `out_line_start` is 1 exactly on the row-0 beat of every column.
- R8: `out_frame_done` is 1 exactly on the final beat (last column, last row). In that same cycle `frame_full` is already 0, so a new input beat can be accepted.
- R9: After a frame has been read out, the next frame is written again from row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Buffer accepts a beat |
| in_l | input | DATA_W | Low-pass coefficient from the row stage |
| in_h | input | DATA_W | High-pass coefficient from the row stage |
| frame_full | output | 1 | Frame stored, read-out in progress |
| out_valid | output | 1 | Output beat present |
| out_line_start | output | 1 | First beat of a column |
| out_frame_done | output | 1 | Last beat of the frame |
| out_l | output | DATA_W | Low-pass stream to the first column processor |
| out_h | output | DATA_W | High-pass stream to the second column processor |

## Verification
Two functions can fall in the same cycle: the final read-out beat, flagged by `out_frame_done`, and the acceptance of the first beat of the next frame. The bench holds `in_valid` high without pause across a frame boundary to make them coincide. It also keeps pushing junk data while the buffer is full.

A behavioural reference with per-cycle state judges the outcome. It checks that the last beat of the old frame arrives intact in the same cycle that the new beat is accepted. It also checks that the new frame later reads back exactly as it was written, which would fail if the junk had landed or the write position had slipped.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/sbt_ram.sv
module sbt_ram #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbt_wr_ctrl.sv
module sbt_wr_ctrl #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = $clog2(ROWS*COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (en) begin
      if (col_q == CW'(COLS-1)) begin
        col_d = '0;
        row_d = (row_q == RW'(ROWS-1)) ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (en) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign addr = AW'(row_q) * AW'(COLS) + AW'(col_q);
  assign last = (row_q == RW'(ROWS-1)) && (col_q == CW'(COLS-1));

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(addr)); // R4
  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> (addr == '0)); // R9
endmodule

// File: rtl/sbt_rd_ctrl.sv
module sbt_rd_ctrl #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = $clog2(ROWS*COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [AW-1:0] addr,
  output logic          first,
  output logic          last
);
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (en) begin
      if (row_q == RW'(ROWS-1)) begin
        row_d = '0;
        col_d = (col_q == CW'(COLS-1)) ? '0 : col_q + 1'b1;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (en) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign addr  = AW'(row_q) * AW'(COLS) + AW'(col_q);
  assign first = (row_q == '0);
  assign last  = (row_q == RW'(ROWS-1)) && (col_q == CW'(COLS-1));

  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> (addr == '0)); // R5
endmodule

// File: rtl/subband_transpose.sv
module subband_transpose #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_l,
  input  logic [DATA_W-1:0] in_h,
  output logic              frame_full,
  output logic              out_valid,
  output logic              out_line_start,
  output logic              out_frame_done,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_h
);
  import sbt_pkg::*;

  localparam int HALF_W = FRAME_W / 2;
  localparam int DEPTH  = HALF_W * FRAME_H;
  localparam int AW     = $clog2(DEPTH);
  localparam int NBANK  = 2;

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  phase_e  phase_q, phase_d;
  logic    wr_en, rd_en, wr_last, rd_last, rd_first;
  logic [AW-1:0] wr_addr, rd_addr;
  logic    valid_q, ls_q, done_q;

  assign frame_full = (phase_q == PH_DRAIN);
  assign in_ready   = rst_n_i && !frame_full;
  assign wr_en      = in_valid && in_ready;
  assign rd_en      = frame_full;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FILL:  if (wr_en && wr_last) phase_d = PH_DRAIN;
      PH_DRAIN: if (rd_last)          phase_d = PH_FILL;
      default:                        phase_d = PH_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_FILL;
      valid_q <= 1'b0;
      ls_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= rd_en;
      ls_q    <= rd_en && rd_first;
      done_q  <= rd_en && rd_last;
    end
  end

  assign out_valid      = valid_q;
  assign out_line_start = ls_q;
  assign out_frame_done = done_q;

  sbt_wr_ctrl #(.ROWS(FRAME_H), .COLS(HALF_W)) u_wr (
    .clk(clk), .rst_n(rst_n_i), .en(wr_en), .addr(wr_addr), .last(wr_last)
  );

  sbt_rd_ctrl #(.ROWS(FRAME_H), .COLS(HALF_W)) u_rd (
    .clk(clk), .rst_n(rst_n_i), .en(rd_en), .addr(rd_addr),
    .first(rd_first), .last(rd_last)
  );

  logic [NBANK-1:0][DATA_W-1:0] wdata_b, rdata_b;
  assign wdata_b[0] = in_l;
  assign wdata_b[1] = in_h;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sbt_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wdata_b[g]),
      .re(rd_en), .raddr(rd_addr), .rdata(rdata_b[g])
    );
  end

  assign out_l = rdata_b[0];
  assign out_h = rdata_b[1];

  AST_VALID_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_valid |-> $past(frame_full)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frame_full && !rd_last) |=> frame_full); // R3
  AST_LS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_line_start |-> out_valid); // R7
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_frame_done |-> out_valid); // R8
  AST_DONE_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_frame_done |-> !frame_full); // R8
endmodule

// File: tb/subband_transpose_tb.sv
module subband_transpose_tb;
  localparam int DW = 10;
  localparam int FW = 8;
  localparam int FH = 8;
  localparam int HC = FW / 2;
  localparam int DEPTH = HC * FH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_l = '0, in_h = '0;
  logic in_ready, frame_full, out_valid, out_line_start, out_frame_done;
  logic [DW-1:0] out_l, out_h;

  always #2.5 clk = ~clk;

  subband_transpose #(.DATA_W(DW), .FRAME_W(FW), .FRAME_H(FH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_h(in_h), .frame_full(frame_full), .out_valid(out_valid),
    .out_line_start(out_line_start), .out_frame_done(out_frame_done),
    .out_l(out_l), .out_h(out_h)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mem_l [DEPTH];
  int mem_h [DEPTH];
  int m_wr = 0, m_rd = 0;
  bit m_full = 0;
  bit e_valid = 0, e_ls = 0, e_done = 0;
  int e_l = 0, e_h = 0;
  int lfsr = 32'h1ACE;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
    return lfsr;
  endfunction

  // behavioural reference: advance one clock with the inputs now applied
  task automatic model_step();
    int r, c;
    e_valid = 0; e_ls = 0; e_done = 0;
    if (!m_full) begin
      if (in_valid) begin
        r = m_wr / HC; c = m_wr % HC;
        mem_l[r*HC+c] = int'(in_l);
        mem_h[r*HC+c] = int'(in_h);
        m_wr++;
        if (m_wr == DEPTH) begin m_wr = 0; m_full = 1; end
      end
    end else begin
      r = m_rd % FH; c = m_rd / FH;
      e_l = mem_l[r*HC+c];
      e_h = mem_h[r*HC+c];
      e_valid = 1;
      e_ls = (r == 0);
      m_rd++;
      if (m_rd == DEPTH) begin m_rd = 0; m_full = 0; e_done = 1; end
    end
  endtask

  task automatic compare();
    chk("R3 in_ready", int'(in_ready), int'(!m_full));
    chk("R3 frame_full", int'(frame_full), int'(m_full));
    chk("R5 out_valid", int'(out_valid), int'(e_valid));
    chk("R7 out_line_start", int'(out_line_start), int'(e_ls));
    chk("R8 out_frame_done", int'(out_frame_done), int'(e_done));
    if (e_done) chk("R8 new beat accepted with done", int'(in_ready), 1);
    if (e_valid) begin
      chk("R6 out_l (R2 R4 R9)", int'(out_l), e_l);
      chk("R6 out_h (R2 R4 R9)", int'(out_h), e_h);
    end
  endtask

  // mode 0: continuous; 1: sparse; junk always offered while full (R4)
  task automatic cycle(input int mode);
    int v;
    v = next_rand();
    in_valid = (mode == 0) ? 1'b1 : v[3];
    in_l = DW'(v >> 4);
    in_h = DW'(v >> 14);
    model_step();
    @(posedge clk);
    #1;
    compare();
    @(negedge clk);
  endtask

  initial begin
    #12;
    chk("R1 in_ready in reset", int'(in_ready), 0);
    chk("R1 frame_full in reset", int'(frame_full), 0);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_frame_done in reset", int'(out_frame_done), 0);
    chk("R1 out_line_start in reset", int'(out_line_start), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in_ready after release", int'(in_ready), 1);
    chk("R1 frame_full after release", int'(frame_full), 0);
    for (int i = 0; i < 2*DEPTH + 4; i++) cycle(0);
    for (int i = 0; i < 6*DEPTH; i++) cycle(1);
    for (int i = 0; i < 4*DEPTH; i++) cycle(0);
    in_valid = 1'b0;
    for (int i = 0; i < 2*DEPTH; i++) cycle(1);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule